// File: doc/BRIEF.md
# BCD Seven-Segment Decoder with Input Hold

This block turns a 4-bit binary-coded-decimal value into the seven active-high segment drives of a common-cathode digit display. Codes 0 to 9 show as decimal digits. The six codes from 10 to 15 have no digit, so they darken the display.

Two active-low overrides sit in front of the decoded pattern. A lamp-test input lights every segment so that a dead segment can be spotted. A blank input turns every segment off. Lamp-test wins over blank, and both win over the digit.

An active-high store input freezes the data path. While store is low the input goes straight through to the decoder with no clock delay. While store is high the decoder is fed the code captured at the last rising clock edge on which store was low, so later changes on the input leave the display alone. The hold applies only to the BCD code. Lamp-test and blank keep acting immediately.

Top module: `bcd_seg_decoder`

## Requirements
- R1: Output `seg` is `{g,f,e,d,c,b,a}` with segment a in bit 0. With lamp-test and blank both high and store low, codes 0 to 9 give 0x3F, 0x06, 0x5B, 0x4F, 0x66, 0x6D, 0x7D, 0x07, 0x7F and 0x6F respectively.
- R2: With lamp-test and blank high, any selected code from 10 to 15 gives `seg` = 0x00.
- R3: While `lamp_test_n` is 0, `seg` is 0x7F whatever the states of blank, store and the code.
- R4: While `lamp_test_n` is 1 and `blank_n` is 0, `seg` is 0x00 whatever the states of store and the code.
- R5: While `store` is 0, the displayed code follows `bcd` in the same cycle, without waiting for a clock edge.
- R6: While `store` is 1, the displayed code is the one present on `bcd` at the last rising edge of `clk` on which `store` was 0. Changes on `bcd` while `store` is 1 have no effect on `seg`.
- R7: The hold does not delay lamp-test or blank. While `store` is 1, both overrides act at once. When both are released, the held digit shows again.
- R8: The asynchronous active-low reset `rst_n` clears the held code to 0. After reset with `store` at 1, `seg` is 0x3F.
- R9: The digit 6 lights its top segment a, giving 0x7D. The digit 9 lights its bottom segment d, giving 0x6F.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock that samples the code for the hold register |
| rst_n | input | 1 | Asynchronous active-low reset of the held code |
| bcd | input | 4 | Binary-coded-decimal input, bit 3 most significant |
| store | input | 1 | 1 = display the held code, 0 = pass `bcd` through |
| lamp_test_n | input | 1 | Active-low lamp test, lights all seven segments |
| blank_n | input | 1 | Active-low blank, turns all segments off |
| seg | output | 7 | Active-high segment drives `{g,f,e,d,c,b,a}` |

## Verification
Every path from `bcd`, `lamp_test_n`, `blank_n` or `store` to `seg` is combinational. These results are due in the same cycle as the stimulus. The bench changes inputs on the falling clock edge and samples `seg` one nanosecond later, before any rising edge can intervene. The only clocked result is the held code. It is captured at a rising edge, so the bench sets up the code, lets exactly one rising edge pass with store low, then raises store on the next falling edge. It compares every later sample against the captured code, however it changes `bcd` afterwards.

// File: rtl/bcd_seg_pkg.sv
package bcd_seg_pkg;

  localparam int CODE_W  = 4;
  localparam int SEG_N   = 7;
  localparam int MAX_DIG = 9;

  typedef logic [CODE_W-1:0] code_t;
  typedef logic [SEG_N-1:0]  seg_t;

  localparam seg_t SEG_ALL  = {SEG_N{1'b1}};
  localparam seg_t SEG_NONE = '0;

  // Segment order {g,f,e,d,c,b,a}; a is bit 0.
  function automatic seg_t digit_pattern(input code_t c);
    seg_t p;
    case (c)
      4'd0:    p = 7'b0111111;
      4'd1:    p = 7'b0000110;
      4'd2:    p = 7'b1011011;
      4'd3:    p = 7'b1001111;
      4'd4:    p = 7'b1100110;
      4'd5:    p = 7'b1101101;
      4'd6:    p = 7'b1111101;
      4'd7:    p = 7'b0000111;
      4'd8:    p = 7'b1111111;
      4'd9:    p = 7'b1101111;
      default: p = SEG_NONE;
    endcase
    return p;
  endfunction

  function automatic logic is_decimal(input code_t c);
    return (int'(c) <= MAX_DIG);
  endfunction

endpackage

// File: rtl/bcd_hold.sv
module bcd_hold
  import bcd_seg_pkg::*;
#(
  parameter int W = CODE_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         store,
  input  logic [W-1:0] code_in,
  output logic [W-1:0] held_out,
  output logic [W-1:0] code_out
);

  logic [W-1:0] held_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      held_q <= '0;
    else if (!store)
      held_q <= code_in;
  end

  assign held_out = held_q;
  assign code_out = store ? held_q : code_in;

endmodule

// File: rtl/digit_decode.sv
module digit_decode
  import bcd_seg_pkg::*;
(
  input  code_t code,
  output logic  valid,
  output seg_t  pattern
);

  assign valid   = is_decimal(code);
  assign pattern = valid ? digit_pattern(code) : SEG_NONE;

endmodule

// File: rtl/seg_priority.sv
module seg_priority
  import bcd_seg_pkg::*;
#(
  parameter int N = SEG_N
) (
  input  logic         lamp_n,
  input  logic         blank_n,
  input  logic [N-1:0] pattern,
  output logic [N-1:0] drive
);

  for (genvar i = 0; i < N; i++) begin : g_seg
    assign drive[i] = !lamp_n | (blank_n & pattern[i]);
  end

endmodule

// File: rtl/bcd_seg_decoder.sv
module bcd_seg_decoder
  import bcd_seg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CODE_W-1:0] bcd,
  input  logic             store,
  input  logic             lamp_test_n,
  input  logic             blank_n,
  output logic [SEG_N-1:0] seg
);

  code_t held_digit;
  code_t digit_sel;
  logic  digit_valid;
  seg_t  digit_seg;

  bcd_hold #(.W(CODE_W)) u_hold (
    .clk      (clk),
    .rst_n    (rst_n),
    .store    (store),
    .code_in  (bcd),
    .held_out (held_digit),
    .code_out (digit_sel)
  );

  digit_decode u_dec (
    .code    (digit_sel),
    .valid   (digit_valid),
    .pattern (digit_seg)
  );

  seg_priority #(.N(SEG_N)) u_pri (
    .lamp_n  (lamp_test_n),
    .blank_n (blank_n),
    .pattern (digit_seg),
    .drive   (seg)
  );

endmodule

// File: rtl/bcd_seg_decoder_chk.sv
module bcd_seg_decoder_chk
  import bcd_seg_pkg::*;
(
  input logic  clk,
  input logic  rst_n,
  input code_t bcd,
  input logic  store,
  input logic  lamp_test_n,
  input logic  blank_n,
  input seg_t  seg,
  input code_t held_digit,
  input code_t digit_sel,
  input logic  digit_valid
);

  // R3
  lamp_all_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lamp_test_n |-> seg == SEG_ALL);

  // R4
  blank_all_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lamp_test_n && !blank_n) |-> seg == SEG_NONE);

  // R2
  nondecimal_dark_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lamp_test_n && blank_n && digit_sel > 4'd9) |-> seg == SEG_NONE);

  // R5
  pass_through_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !store |-> digit_sel == bcd);

  // R6
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (store && $past(store)) |-> $stable(held_digit));

  // R6
  hold_feeds_decoder_chk: assert property (@(posedge clk) disable iff (!rst_n)
    store |-> digit_sel == held_digit);

  // R1
  valid_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lamp_test_n && blank_n && digit_valid) |-> seg != SEG_NONE);

endmodule

bind bcd_seg_decoder bcd_seg_decoder_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .bcd         (bcd),
  .store       (store),
  .lamp_test_n (lamp_test_n),
  .blank_n     (blank_n),
  .seg         (seg),
  .held_digit  (held_digit),
  .digit_sel   (digit_sel),
  .digit_valid (digit_valid)
);

// File: tb/bcd_seg_decoder_test.sv
`timescale 1ns/1ps
module bcd_seg_decoder_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] bcd = 4'd0;
  logic       store = 1'b0;
  logic       lamp_test_n = 1'b1;
  logic       blank_n = 1'b1;
  logic [6:0] seg;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  bcd_seg_decoder uut (
    .clk         (clk),
    .rst_n       (rst_n),
    .bcd         (bcd),
    .store       (store),
    .lamp_test_n (lamp_test_n),
    .blank_n     (blank_n),
    .seg         (seg)
  );

  // Expected segments from per-segment membership rules, bit 0 = a.
  function automatic logic [6:0] expect_digit(input int d);
    logic [6:0] e;
    if (d > 9) return 7'd0;
    e[0] = !(d == 1 || d == 4);
    e[1] = !(d == 5 || d == 6);
    e[2] = (d != 2);
    e[3] = !(d == 1 || d == 4 || d == 7);
    e[4] = (d == 0 || d == 2 || d == 6 || d == 8);
    e[5] = !(d == 1 || d == 2 || d == 3 || d == 7);
    e[6] = !(d == 0 || d == 1 || d == 7);
    return e;
  endfunction

  function automatic logic [6:0] expect_out(input logic lt_n, input logic bl_n, input int d);
    if (!lt_n) return 7'h7F;
    if (!bl_n) return 7'h00;
    return expect_digit(d);
  endfunction

  task automatic check(input string req, input logic [6:0] exp_v);
    checks++;
    if (seg !== exp_v) begin
      fails++;
      $display("FAIL %s: seg=%h expected=%h (bcd=%0d store=%b lt_n=%b bl_n=%b)",
               req, seg, exp_v, bcd, store, lamp_test_n, blank_n);
    end
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    // R8: reset clears held code; store high shows 0
    store = 1'b1;
    bcd = 4'd7;
    repeat (3) @(negedge clk);
    #1 check("R8", 7'h3F);
    rst_n = 1'b1;
    @(negedge clk);
    #1 check("R8", 7'h3F);

    // R1 R2 R3 R4 R5: transparent sweep of all codes and override pairs
    store = 1'b0;
    for (int lt = 0; lt < 2; lt++) begin
      for (int bl = 0; bl < 2; bl++) begin
        for (int d = 0; d < 16; d++) begin
          @(negedge clk);
          lamp_test_n = lt[0];
          blank_n = bl[0];
          bcd = d[3:0];
          #1;
          if (!lt[0]) check("R3", expect_out(lt[0], bl[0], d));
          else if (!bl[0]) check("R4", expect_out(lt[0], bl[0], d));
          else if (d > 9) check("R2", expect_out(lt[0], bl[0], d));
          else check("R1", expect_out(lt[0], bl[0], d));
        end
      end
    end

    // R5: output follows bcd between clock edges
    @(negedge clk);
    lamp_test_n = 1'b1; blank_n = 1'b1; store = 1'b0;
    bcd = 4'd2; #1 check("R5", expect_digit(2));
    bcd = 4'd5; #1 check("R5", expect_digit(5));

    // R9: tail segments
    bcd = 4'd6; #1 check("R9", 7'h7D);
    bcd = 4'd9; #1 check("R9", 7'h6F);

    // R6 R7: hold every code, disturb input and overrides
    for (int d = 0; d < 16; d++) begin
      @(negedge clk);
      store = 1'b0;
      bcd = d[3:0];
      @(negedge clk);
      store = 1'b1;
      for (int k = 0; k < 16; k++) begin
        bcd = k[3:0];
        #1 check("R6", expect_digit(d));
      end
      @(negedge clk);
      bcd = ~d[3:0];
      #1 check("R6", expect_digit(d));
      lamp_test_n = 1'b0;
      #1 check("R7", 7'h7F);
      lamp_test_n = 1'b1; blank_n = 1'b0;
      #1 check("R7", 7'h00);
      blank_n = 1'b1;
      @(negedge clk);
      #1 check("R7", expect_digit(d));
    end

    // R5: releasing store returns to live input at once
    @(negedge clk);
    bcd = 4'd3;
    store = 1'b0;
    #1 check("R5", expect_digit(3));

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule